// File: doc/BRIEF.md
# Synthesizer Tuning-Word Programming Front End

This block is the programming side of a direct digital synthesizer. A host writes a 40-bit tuning word, made of a 32-bit frequency word and an 8-bit control byte, into an input register. The word goes in either as five bytes on an 8-bit bus or as forty single bits on the top bus pin. Each piece is clocked in by a load strobe. A separate update strobe then copies the whole input register into the working registers that drive the synthesis core. The two registers form a double buffer, so the core never runs on a half-written word.

Both strobes are asynchronous to the system clock. Each one passes through a two-flop synchronizer and a rising-edge detector, so every register change takes place on a system clock edge. The core is a 32-bit phase accumulator. On each clock it adds the working frequency word. Its phase output is the top bits of the accumulator plus a 5-bit phase offset, where one offset step is 1/32 of a turn.

Reset clears the core state, returns the block to byte mode and turns off the multiplier enable. Reset leaves the input register untouched.

Top module: `tw_load_front`

## Requirements
- R1: In byte mode the load strobes fill five slots in a fixed order. The first byte is the control byte (word bits 39:32). The next four are the frequency word from its most significant byte (bits 31:24) to its least significant byte (bits 7:0). After the fifth byte the slot counter wraps back to the control slot.
- R2: A rising update strobe copies the input register into the working registers as follows:
  - the frequency word comes from word bits 31:0;
  - the phase offset comes from control bits 7:3;
  - the serial-mode flag comes from control bit 1;
  - the multiplier enable comes from control bit 0.
- R3: Load strobes never change the working registers or the mode. Only an update strobe does.
- R4: In serial mode each load strobe shifts in `data_in[7]` and ignores bits 6:0. The 40 bits arrive least significant first: frequency bit 0 first and control bit 7 last.
- R5: The mode changes only on an update strobe. Control bit 1 = 1 selects serial mode and 0 selects byte mode. Loading that byte does not switch the mode until the update.
- R6: An update strobe returns the byte slot counter to the control slot, so a partial byte load is abandoned.
- R7: While reset is high, the block clears the accumulator, the working frequency word, the phase offset, the multiplier enable and the slot counter, and it selects byte mode. The phase output is then 0.
- R8: Reset does not alter the input register. An update after reset transfers the word that was loaded before reset.
- R9: On every clock the accumulator adds the working frequency word, modulo 2^32. `phase_out` is (accumulator bits 31:32-OUT_W + offset·2^(OUT_W-5)) mod 2^OUT_W.
- R10: A strobe that rises between two clock edges takes effect at the third rising clock edge after it. The result is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Byte bus; bit 7 is the MSB and is also the serial data pin |
| wload_strobe | input | 1 | Load strobe, asynchronous; acts on its rising edge |
| upd_strobe | input | 1 | Update strobe, asynchronous; acts on its rising edge |
| freq_word | output | 32 | Working frequency word |
| phase_off | output | 5 | Working phase offset, in steps of 1/32 turn |
| mult_en | output | 1 | Working reference-multiplier enable |
| serial_mode | output | 1 | 1 when serial loading is selected |
| phase_out | output | OUT_W | Accumulator phase plus offset |

## Verification
A strobe that rises between two clock edges is seen by the logic only after the synchronizer and the edge detector. The load or the copy therefore lands on the third rising edge after the strobe, and the bench checks the old value after two edges and the new value after the third. The accumulator output changes on every edge from then on. For that reason the phase checks sample on consecutive falling edges and compare the step between samples with the working frequency word, not with an absolute value. Every strobe is held for three cycles and released for three more, so each event is complete before the next one is driven.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int FREQ_W        = 32;
  localparam int CTRL_W        = 8;
  localparam int BYTE_W        = 8;
  localparam int WORD_W        = FREQ_W + CTRL_W;
  localparam int BYTES         = WORD_W / BYTE_W;
  localparam int SLOT_W        = $clog2(BYTES);
  localparam int OFF_W         = 5;
  localparam int CTRL_MULT_BIT = 0;
  localparam int CTRL_SER_BIT  = 1;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [FREQ_W-1:0] freq;
  } tword_t;

  function automatic logic [OFF_W-1:0] ctrl_offset(logic [CTRL_W-1:0] c);
    return c[CTRL_W-1 -: OFF_W];
  endfunction

  function automatic logic ctrl_serial(logic [CTRL_W-1:0] c);
    return c[CTRL_SER_BIT];
  endfunction

  function automatic logic ctrl_mult(logic [CTRL_W-1:0] c);
    return c[CTRL_MULT_BIT];
  endfunction
endpackage

// File: rtl/tw_strobe_sync.sv
module tw_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic evt
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], strobe};
  end

  assign evt = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tw_input_reg.sv
module tw_input_reg
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wload_evt,
  input  logic              upd_evt,
  input  logic              serial_mode,
  input  logic [BYTE_W-1:0] data_in,
  output logic [WORD_W-1:0] word,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BYTES - 1);

  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst)                             slot_q <= '0;
    else if (upd_evt)                    slot_q <= '0;
    else if (wload_evt && !serial_mode)  slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst && wload_evt) begin
      if (serial_mode) begin
        word_q <= {data_in[BYTE_W-1], word_q[WORD_W-1:1]};
      end else begin
        for (int s = 0; s < BYTES; s++) begin
          if (slot_q == SLOT_W'(s)) word_q[WORD_W-1-BYTE_W*s -: BYTE_W] <= data_in;
        end
      end
    end
  end

  assign word = word_q;
  assign slot = slot_q;
endmodule

// File: rtl/tw_phase_core.sv
module tw_phase_core
  import tw_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_evt,
  input  logic [WORD_W-1:0] in_word,
  output logic [FREQ_W-1:0] freq_word,
  output logic [OFF_W-1:0]  phase_off,
  output logic              mult_en,
  output logic              serial_mode,
  output logic [FREQ_W-1:0] acc,
  output logic [OUT_W-1:0]  phase_out
);
  function automatic logic [OUT_W-1:0] phase_mix(logic [FREQ_W-1:0] a, logic [OFF_W-1:0] off);
    return a[FREQ_W-1 -: OUT_W] + {off, {(OUT_W-OFF_W){1'b0}}};
  endfunction

  tword_t w;
  assign w = tword_t'(in_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_word   <= '0;
      phase_off   <= '0;
      mult_en     <= 1'b0;
      serial_mode <= 1'b0;
    end else if (upd_evt) begin
      freq_word   <= w.freq;
      phase_off   <= ctrl_offset(w.ctrl);
      mult_en     <= ctrl_mult(w.ctrl);
      serial_mode <= ctrl_serial(w.ctrl);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + freq_word;
  end

  assign phase_out = phase_mix(acc, phase_off);
endmodule

// File: rtl/tw_load_front.sv
module tw_load_front
  import tw_pkg::*;
#(
  parameter int OUT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       data_in,
  input  logic             wload_strobe,
  input  logic             upd_strobe,
  output logic [31:0]      freq_word,
  output logic [4:0]       phase_off,
  output logic             mult_en,
  output logic             serial_mode,
  output logic [OUT_W-1:0] phase_out
);
  logic              wload_evt;
  logic              upd_evt;
  logic [WORD_W-1:0] in_word;
  logic [SLOT_W-1:0] slot_q;
  logic [FREQ_W-1:0] acc_q;

  tw_strobe_sync #(.STAGES(SYNC_STAGES)) u_wload_sync (
    .clk(clk), .rst(rst), .strobe(wload_strobe), .evt(wload_evt)
  );

  tw_strobe_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk(clk), .rst(rst), .strobe(upd_strobe), .evt(upd_evt)
  );

  tw_input_reg u_in_reg (
    .clk(clk), .rst(rst), .wload_evt(wload_evt), .upd_evt(upd_evt),
    .serial_mode(serial_mode), .data_in(data_in), .word(in_word), .slot(slot_q)
  );

  tw_phase_core #(.OUT_W(OUT_W)) u_core (
    .clk(clk), .rst(rst), .upd_evt(upd_evt), .in_word(in_word),
    .freq_word(freq_word), .phase_off(phase_off), .mult_en(mult_en),
    .serial_mode(serial_mode), .acc(acc_q), .phase_out(phase_out)
  );
endmodule

// File: rtl/tw_load_front_chk.sv
module tw_load_front_chk #(
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             wload_evt,
  input logic             upd_evt,
  input logic [39:0]      in_word,
  input logic [2:0]       slot_q,
  input logic [31:0]      acc_q,
  input logic [31:0]      freq_word,
  input logic [4:0]       phase_off,
  input logic             mult_en,
  input logic             serial_mode,
  input logic [OUT_W-1:0] phase_out
);
  p_slot_range_r1: assert property (@(posedge clk) disable iff (rst)
    wload_evt |=> (slot_q < 3'd5));

  p_update_copy_r2: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> (freq_word == $past(in_word[31:0]) && phase_off == $past(in_word[39:35])
                 && serial_mode == $past(in_word[33]) && mult_en == $past(in_word[32])));

  p_work_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !upd_evt |=> ($stable(freq_word) && $stable(phase_off) && $stable(mult_en)));

  p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !upd_evt |=> $stable(serial_mode));

  p_slot_clear_r6: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> (slot_q == 3'd0));

  p_reset_state_r7: assert property (@(posedge clk)
    rst |=> (acc_q == 32'd0 && freq_word == 32'd0 && phase_off == 5'd0
             && !mult_en && !serial_mode && slot_q == 3'd0));

  p_in_keep_r8: assert property (@(posedge clk)
    rst |=> $stable(in_word));

  p_acc_step_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (acc_q == $past(acc_q) + $past(freq_word)));
endmodule

bind tw_load_front tw_load_front_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .wload_evt(wload_evt), .upd_evt(upd_evt),
  .in_word(in_word), .slot_q(slot_q), .acc_q(acc_q), .freq_word(freq_word),
  .phase_off(phase_off), .mult_en(mult_en), .serial_mode(serial_mode),
  .phase_out(phase_out)
);

// File: tb/tw_load_front_tb_top.sv
`timescale 1ns/1ps
module tw_load_front_tb_top;
  localparam int OW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    data_in = 8'h00;
  logic          wload_strobe = 1'b0;
  logic          upd_strobe = 1'b0;
  logic [31:0]   freq_word;
  logic [4:0]    phase_off;
  logic          mult_en;
  logic          serial_mode;
  logic [OW-1:0] phase_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tw_load_front #(.OUT_W(OW)) dut_i (
    .clk(clk), .rst(rst), .data_in(data_in), .wload_strobe(wload_strobe),
    .upd_strobe(upd_strobe), .freq_word(freq_word), .phase_off(phase_off),
    .mult_en(mult_en), .serial_mode(serial_mode), .phase_out(phase_out)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wload(logic [7:0] b);
    data_in = b; wload_strobe = 1'b1;
    repeat (3) @(negedge clk);
    wload_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic update();
    upd_strobe = 1'b1;
    repeat (3) @(negedge clk);
    upd_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic par_load(logic [7:0] c, logic [31:0] f);
    wload(c);
    for (int i = 3; i >= 0; i--) wload(f[8*i +: 8]);
  endtask

  task automatic t_reset();
    do_reset();
    check("R7 freq", freq_word, 0);
    check("R7 offset", phase_off, 0);
    check("R7 mult", mult_en, 0);
    check("R7 mode", serial_mode, 0);
    check("R7 phase", phase_out, 0);
  endtask

  task automatic t_parallel_timing();
    par_load(8'h00, 32'h12345678);
    check("R3 freq before update", freq_word, 0);
    upd_strobe = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 not yet after two edges", freq_word, 0);
    @(negedge clk);
    check("R10 R2 copied on third edge", freq_word, 32'h12345678);
    upd_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_wrap();
    par_load(8'h00, 32'h11111111);
    par_load(8'h00, 32'hCAFEF00D);
    update();
    check("R1 wrap after five bytes", freq_word, 32'hCAFEF00D);
  endtask

  task automatic t_partial();
    wload(8'h00);
    wload(8'hAA);
    update();
    check("R6 partial load", freq_word, 32'hAAFEF00D);
    par_load(8'h00, 32'h0BADBEEF);
    update();
    check("R6 restart at control slot", freq_word, 32'h0BADBEEF);
  endtask

  task automatic t_offset();
    do_reset();
    par_load({5'd9, 3'b001}, 32'h0);
    update();
    check("R2 offset", phase_off, 9);
    check("R2 mult", mult_en, 1);
    check("R9 offset phase", phase_out, 9 * (1 << (OW - 5)));
    @(negedge clk);
    check("R9 zero freq holds phase", phase_out, 9 * (1 << (OW - 5)));
  endtask

  task automatic t_accum();
    logic [OW-1:0] p0;
    par_load({5'd9, 3'b000}, 32'(3) << (32 - OW));
    update();
    for (int k = 0; k < 4; k++) begin
      p0 = phase_out;
      @(negedge clk);
      check("R9 phase step", OW'(phase_out - p0), 3);
    end
  endtask

  task automatic t_serial();
    logic [39:0] w;
    par_load(8'h02, 32'h0);
    check("R5 mode unchanged before update", serial_mode, 0);
    update();
    check("R5 serial after update", serial_mode, 1);
    w = {8'h2A, 32'h89ABCDEF};
    for (int i = 0; i < 40; i++) wload(w[i] ? 8'h95 : 8'h6A);
    check("R3 freq held during serial load", freq_word, 0);
    update();
    check("R4 serial freq", freq_word, 32'h89ABCDEF);
    check("R4 serial offset", phase_off, 5);
    check("R5 stays serial", serial_mode, 1);
  endtask

  task automatic t_reset_keep();
    do_reset();
    check("R7 mode back to byte", serial_mode, 0);
    check("R7 freq cleared", freq_word, 0);
    update();
    check("R8 input kept freq", freq_word, 32'h89ABCDEF);
    check("R8 input kept offset", phase_off, 5);
  endtask

  initial begin
    t_reset();
    t_parallel_timing();
    t_wrap();
    t_partial();
    t_offset();
    t_accum();
    t_serial();
    t_reset_keep();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule